// File: doc/BRIEF.md
# Masked-Write GPIO Pin Bank

This block is the register front end of one bank of up to 32 general-purpose pins. Software reaches it over a flat 32-bit register bus with an address, a write strobe, write data and combinational read data. The bank keeps three per-pin state words: the value each pin drives, whether the pin is an output, and whether its driver is switched on. It produces a per-pin drive value and a per-pin tri-state enable for the pad ring, and it returns the synchronized pad levels to software.

The drive value has no plain read/write register. It is changed only through two half-word ports, one for pins 0-15 and one for pins 16-31. Each word written to these ports carries an active-low per-bit protect mask in its upper half and new pin values in its lower half. Firmware can therefore set or clear any group of pins in one bus write, without a read-modify-write that could race with another writer. The bank can be built with fewer than 32 pins, and a parameter can name pins that must never be turned back into inputs once they are outputs.

Top module: `pinbank_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the direction, driver-enable and drive-value state are all zero, so `pin_out` and `pin_oe` are 0 and the direction and enable registers read 0.
- R2: A write to offset 0x000 updates drive bit i (i = 0..15) to write-data bit i when write-data bit 16+i is 0, and leaves drive bit i unchanged when bit 16+i is 1.
- R3: A write to offset 0x004 updates drive bit 16+i (i = 0..15) to write-data bit i when write-data bit 16+i is 0, and leaves it unchanged when bit 16+i is 1.
- R4: Reads of offsets 0x000 and 0x004 return 0.
- R5: The direction register at offset 0x204 is read/write, one bit per pin, bit n for pin n, with 1 meaning output.
- R6: The driver-enable register at offset 0x208 is read/write, and `pin_oe[n]` is 1 only when both the direction bit and the driver-enable bit of pin n are 1.
- R7: A read of offset 0x060 returns the pad level of pin n in bit n, taken through a two-flop synchronizer: a change on `pin_in` first shows on the bus after the second rising clock edge, whatever the pin direction.
- R8: For pins at or above `NUM_PINS`, writes are ignored, every readable register returns 0 in those bits, and `pin_out` and `pin_oe` stay 0.
- R9: For pins named in `FORCE_OUT`, writing 0 to a direction bit that is already 1 leaves it 1.
- R10: Reads of any other offset return 0, and writes to any other offset change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 12 | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Raw pad levels, asynchronous to `clk` |
| pin_out | output | 32 | Drive value per pin |
| pin_oe | output | 32 | Tri-state enable per pin, 1 drives the pad |

## Verification
The hardest case to reach is a direction bit on a force-output pin that software tries to clear. The pin must first be made an output, and only a later write of 0 shows whether the bit is sticky. The stimulus makes a wide direction write, then sets the forced pins alone, then writes all zeros. It reads the register back and checks `pin_oe` against an enable word that overlaps both forced and ordinary pins. A second subtle point is the synchronizer delay: the pad-level read is checked both one edge after a pin change, when it must still hold the old value, and two edges after.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

  localparam int BUS_W  = 32;
  localparam int HALF_W = BUS_W / 2;
  localparam int ADDR_W = 12;

  // Register offsets; software depends on these exact values.
  localparam logic [ADDR_W-1:0] OFS_DRV_LO = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_DRV_HI = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_LEVEL  = 12'h060;
  localparam logic [ADDR_W-1:0] OFS_DIR    = 12'h204;
  localparam logic [ADDR_W-1:0] OFS_DRVEN  = 12'h208;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DRV_LO,
    SEL_DRV_HI,
    SEL_LEVEL,
    SEL_DIR,
    SEL_DRVEN
  } reg_sel_e;

  function automatic logic [BUS_W-1:0] impl_mask(int n);
    logic [BUS_W-1:0] m;
    m = '0;
    for (int i = 0; i < BUS_W; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/pinbank_rst_sync.sv
module pinbank_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ln
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_ln = chain_q[STAGES-1];

endmodule

// File: rtl/pinbank_in_sync.sv
module pinbank_in_sync
  import pinbank_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst_ln,
  input  logic [BUS_W-1:0] pin_in,
  output logic [BUS_W-1:0] level
);

  for (genvar p = 0; p < BUS_W; p++) begin : g_pin
    if (p < NUM_PINS) begin : g_live
      logic [STAGES-1:0] st_q;
      logic [STAGES-1:0] st_d;

      always_comb begin
        st_d = {st_q[STAGES-2:0], pin_in[p]};
      end

      always_ff @(posedge clk or negedge rst_ln) begin
        if (!rst_ln) begin
          st_q <= '0;
        end else begin
          st_q <= st_d;
        end
      end

      assign level[p] = st_q[STAGES-1];
    end else begin : g_absent
      assign level[p] = 1'b0;
    end
  end

endmodule

// File: rtl/pinbank_decode.sv
module pinbank_decode
  import pinbank_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  always_comb begin
    unique case (addr)
      OFS_DRV_LO: sel = SEL_DRV_LO;
      OFS_DRV_HI: sel = SEL_DRV_HI;
      OFS_LEVEL:  sel = SEL_LEVEL;
      OFS_DIR:    sel = SEL_DIR;
      OFS_DRVEN:  sel = SEL_DRVEN;
      default:    sel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/pinbank_drvreg.sv
module pinbank_drvreg
  import pinbank_pkg::*;
#(
  parameter logic [BUS_W-1:0] IMPL_MASK = '1
) (
  input  logic             clk,
  input  logic             rst_ln,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] drv_q
);

  logic [BUS_W-1:0] drv_d;
  logic             drv_en;

  assign drv_en = wr_lo | wr_hi;

  // Upper half of the bus word is an active-low protect mask.
  always_comb begin
    drv_d = drv_q;
    for (int i = 0; i < HALF_W; i++) begin
      if (wr_lo && !wdata[HALF_W+i]) drv_d[i]        = wdata[i];
      if (wr_hi && !wdata[HALF_W+i]) drv_d[HALF_W+i] = wdata[i];
    end
    drv_d = drv_d & IMPL_MASK;
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      drv_q <= '0;
    end else if (drv_en) begin
      drv_q <= drv_d;
    end
  end

endmodule

// File: rtl/pinbank_cfgreg.sv
module pinbank_cfgreg
  import pinbank_pkg::*;
#(
  parameter logic [BUS_W-1:0] IMPL_MASK   = '1,
  parameter logic [BUS_W-1:0] STICKY_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_ln,
  input  logic             wr,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] cfg_q
);

  logic [BUS_W-1:0] cfg_d;

  // Sticky bits can be set by software but never cleared by it.
  always_comb begin
    cfg_d = (wdata | (cfg_q & STICKY_MASK)) & IMPL_MASK;
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      cfg_q <= '0;
    end else if (wr) begin
      cfg_q <= cfg_d;
    end
  end

endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int               NUM_PINS  = 32,
  parameter logic [BUS_W-1:0] FORCE_OUT = '0,
  parameter int               SYNC_LEN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [BUS_W-1:0]  pin_in,
  output logic [BUS_W-1:0]  pin_out,
  output logic [BUS_W-1:0]  pin_oe
);

  localparam logic [BUS_W-1:0] IMPL_MASK  = impl_mask(NUM_PINS);
  localparam logic [BUS_W-1:0] FORCE_MASK = FORCE_OUT & IMPL_MASK;

  logic             rst_sync_n;
  reg_sel_e         sel;
  logic [BUS_W-1:0] level;
  logic [BUS_W-1:0] drv_q;
  logic [BUS_W-1:0] dir_q;
  logic [BUS_W-1:0] den_q;

  pinbank_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ln (rst_sync_n)
  );

  pinbank_decode u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  pinbank_in_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_LEN)) u_sync (
    .clk    (clk),
    .rst_ln (rst_sync_n),
    .pin_in (pin_in),
    .level  (level)
  );

  pinbank_drvreg #(.IMPL_MASK(IMPL_MASK)) u_drv (
    .clk    (clk),
    .rst_ln (rst_sync_n),
    .wr_lo  (bus_we && sel == SEL_DRV_LO),
    .wr_hi  (bus_we && sel == SEL_DRV_HI),
    .wdata  (bus_wdata),
    .drv_q  (drv_q)
  );

  pinbank_cfgreg #(.IMPL_MASK(IMPL_MASK), .STICKY_MASK(FORCE_MASK)) u_dir (
    .clk    (clk),
    .rst_ln (rst_sync_n),
    .wr     (bus_we && sel == SEL_DIR),
    .wdata  (bus_wdata),
    .cfg_q  (dir_q)
  );

  pinbank_cfgreg #(.IMPL_MASK(IMPL_MASK), .STICKY_MASK('0)) u_den (
    .clk    (clk),
    .rst_ln (rst_sync_n),
    .wr     (bus_we && sel == SEL_DRVEN),
    .wdata  (bus_wdata),
    .cfg_q  (den_q)
  );

  always_comb begin
    unique case (sel)
      SEL_LEVEL: bus_rdata = level;
      SEL_DIR:   bus_rdata = dir_q;
      SEL_DRVEN: bus_rdata = den_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign pin_out = drv_q;
  assign pin_oe  = dir_q & den_q;

endmodule

// File: rtl/pinbank_ctrl_chk.sv
module pinbank_ctrl_chk
  import pinbank_pkg::*;
#(
  parameter logic [BUS_W-1:0] IMPL_MASK  = '1,
  parameter logic [BUS_W-1:0] FORCE_MASK = '0
) (
  input logic              clk,
  input logic              rst_ln,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic [BUS_W-1:0]  pin_in,
  input logic [BUS_W-1:0]  pin_out,
  input logic [BUS_W-1:0]  pin_oe,
  input logic [BUS_W-1:0]  dir_q
);

  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      age_q <= '0;
    end else if (age_q != 2'd2) begin
      age_q <= age_q + 2'd1;
    end
  end

  p_lo_protect_r2: assert property (@(posedge clk) disable iff (!rst_ln)
    (bus_we && bus_addr == OFS_DRV_LO) |=>
      ((pin_out[HALF_W-1:0] & $past(bus_wdata[BUS_W-1:HALF_W])) ==
       ($past(pin_out[HALF_W-1:0]) & $past(bus_wdata[BUS_W-1:HALF_W]))));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_ln)
    !bus_we |=> $stable(pin_out));

  p_hi_protect_r3: assert property (@(posedge clk) disable iff (!rst_ln)
    (bus_we && bus_addr == OFS_DRV_HI) |=>
      ((pin_out[BUS_W-1:HALF_W] & $past(bus_wdata[BUS_W-1:HALF_W])) ==
       ($past(pin_out[BUS_W-1:HALF_W]) & $past(bus_wdata[BUS_W-1:HALF_W]))));

  p_wo_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_ln)
    (bus_addr == OFS_DRV_LO || bus_addr == OFS_DRV_HI) |-> (bus_rdata == '0));

  p_oe_needs_dir_r6: assert property (@(posedge clk) disable iff (!rst_ln)
    (pin_oe != '0) |-> ((pin_oe & ~dir_q) == '0));

  p_level_delay_r7: assert property (@(posedge clk) disable iff (!rst_ln)
    (age_q == 2'd2 && bus_addr == OFS_LEVEL) |->
      (bus_rdata == ($past(pin_in, 2) & IMPL_MASK)));

  p_absent_pins_r8: assert property (@(posedge clk) disable iff (!rst_ln)
    (pin_oe != '0 || pin_out != '0) |-> (((pin_out | pin_oe) & ~IMPL_MASK) == '0));

  p_force_sticky_r9: assert property (@(posedge clk) disable iff (!rst_ln)
    (|(dir_q & FORCE_MASK)) |=> ((($past(dir_q) & FORCE_MASK) & ~dir_q) == '0));

endmodule

bind pinbank_ctrl pinbank_ctrl_chk #(
  .IMPL_MASK  (IMPL_MASK),
  .FORCE_MASK (FORCE_MASK)
) u_chk (
  .clk       (clk),
  .rst_ln    (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_in    (pin_in),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .dir_q     (dir_q)
);

// File: tb/tb_pinbank_ctrl.sv
module tb_pinbank_ctrl;

  localparam int          NPINS = 22;
  localparam logic [31:0] FORCE = 32'h0000_0180;

  logic        clk;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  pinbank_ctrl #(.NUM_PINS(NPINS), .FORCE_OUT(FORCE), .SYNC_LEN(2)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // op: 0 write, 1 compare read data, 2 compare pin_out, 3 compare pin_oe
  // fields: {op[1:0], req[3:0], addr[11:0], data[31:0]}
  localparam int NV = 28;
  localparam logic [49:0] VEC [NV] = '{
    {2'd0, 4'd2,  12'h000, 32'h0000_A5C3},  // R2 all bits unprotected
    {2'd2, 4'd2,  12'h000, 32'h0000_A5C3},
    {2'd0, 4'd2,  12'h000, 32'hFF00_0011},  // R2 bits 15:8 protected
    {2'd2, 4'd2,  12'h000, 32'h0000_A511},
    {2'd0, 4'd3,  12'h004, 32'h0000_FFFF},  // R3 / R8 only pins 16..21 exist
    {2'd2, 4'd8,  12'h000, 32'h003F_A511},
    {2'd0, 4'd3,  12'h004, 32'hFFF5_0000},  // R3 clear pins 17 and 19
    {2'd2, 4'd3,  12'h000, 32'h0035_A511},
    {2'd1, 4'd4,  12'h000, 32'h0000_0000},  // R4
    {2'd1, 4'd4,  12'h004, 32'h0000_0000},  // R4
    {2'd0, 4'd5,  12'h204, 32'hFFFF_F00F},  // R5
    {2'd1, 4'd8,  12'h204, 32'h003F_F00F},  // R8 upper bits dropped
    {2'd3, 4'd6,  12'h000, 32'h0000_0000},  // R6 enable still off
    {2'd0, 4'd6,  12'h208, 32'h0000_0FF3},
    {2'd1, 4'd6,  12'h208, 32'h0000_0FF3},
    {2'd3, 4'd6,  12'h000, 32'h0000_0003},  // R6 dir & enable
    {2'd0, 4'd9,  12'h204, 32'h0000_0180},
    {2'd1, 4'd5,  12'h204, 32'h0000_0180},
    {2'd0, 4'd9,  12'h204, 32'h0000_0000},  // R9 clear attempt on forced pins
    {2'd1, 4'd9,  12'h204, 32'h0000_0180},
    {2'd3, 4'd9,  12'h000, 32'h0000_0180},
    {2'd0, 4'd10, 12'h300, 32'hFFFF_FFFF},  // R10 unmapped write
    {2'd1, 4'd10, 12'h300, 32'h0000_0000},
    {2'd1, 4'd10, 12'h204, 32'h0000_0180},
    {2'd2, 4'd10, 12'h000, 32'h0035_A511},
    {2'd0, 4'd8,  12'h208, 32'hFFFF_FFFF},
    {2'd1, 4'd8,  12'h208, 32'h003F_FFFF},
    {2'd3, 4'd8,  12'h000, 32'h0000_0180}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic write_reg(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic read_check(string req, logic [11:0] a, logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    bus_addr  = '0;
    bus_we    = 1'b0;
    bus_wdata = '0;
    pin_in    = '0;
    repeat (3) @(negedge clk);
    check("R1", pin_out, 32'h0);
    check("R1", pin_oe, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    read_check("R1", 12'h204, 32'h0);
    read_check("R1", 12'h208, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [3:0]  rq;
      logic [11:0] ad;
      logic [31:0] dt;
      string       tag;
      {op, rq, ad, dt} = VEC[i];
      tag = $sformatf("R%0d", rq);
      case (op)
        2'd0: write_reg(ad, dt);
        2'd1: read_check(tag, ad, dt);
        2'd2: begin @(negedge clk); #1; check(tag, pin_out, dt); end
        default: begin @(negedge clk); #1; check(tag, pin_oe, dt); end
      endcase
    end

    // R7: pad levels through two flops, independent of direction
    @(negedge clk);
    bus_addr = 12'h060;
    pin_in   = 32'hFFFF_FFFF;
    @(negedge clk); #1;
    check("R7", bus_rdata, 32'h0000_0000);
    @(negedge clk); #1;
    check("R7", bus_rdata, 32'h003F_FFFF);
    pin_in = 32'h0012_3456;
    repeat (2) @(negedge clk); #1;
    check("R7", bus_rdata, 32'h0012_3456);
    pin_in = 32'hFFC0_0000;
    repeat (2) @(negedge clk); #1;
    check("R8", bus_rdata, 32'h0000_0000);

    // R1: asynchronous reset in mid-run clears everything, forced bits too
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", pin_out, 32'h0);
    check("R1", pin_oe, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    read_check("R1", 12'h204, 32'h0);
    read_check("R1", 12'h208, 32'h0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule